// File: doc/BRIEF.md
# I2C Master Asymmetric SCL Generator

This block produces the serial clock for an I2C master and tells the master's bit engine when to act on SDA. A 16-bit divider word sets the two halves of the clock independently. The upper byte sets the released (high) half and the lower byte sets the driven-low half. Each half lasts its byte value plus two input cycles, so a single word can give a symmetric 100 kHz clock (both bytes 0xCF) or an asymmetric 400 kHz clock (upper 0x28, lower 0x3C).

The bit engine asks for one operation at a time: a start (or a repeated start), a data bit, a stop, or a return to idle. Each request is a one-cycle pulse that is accepted only while `ready_o` is high. The generator then walks through the low and high phases. It pulses `sda_upd_o` in the middle of a low phase, when SDA may change, and `sda_smp_o` in the middle of a high phase, when SDA should be read. It pulses `sda_sta_o` or `sda_sto_o` while SCL is high, at the moment SDA must fall or rise for a start or a stop. Any device on the bus may stretch the clock by holding SCL low: the generator waits until the synchronised line reads high before it counts the high phase, and it pauses that count whenever the line is pulled low again.

Top module: `i2c_scl_gen`

## Requirements
- R1: After reset SCL is released (`scl_low_o`=0), `ready_o`=1, `done_o`=0 and no strobe is active.
- R2: For a bit request, `scl_low_o` stays 1 for exactly (low byte + 2) cycles, counted from the cycle after the accepting clock edge, and then goes to 0.
- R3: After release, the high phase counts (high byte + 2) cycles once the SCL input, passed through a 2-stage synchroniser, reads high. With an undisturbed line, release to the end of a bit therefore takes 3 + high byte + 2 cycles.
- R4: `sda_upd_o` pulses exactly once per low phase, in low-phase cycle floor((low byte + 2)/2). Low-phase cycles are counted from 0, and it is only ever active while `scl_low_o`=1.
- R5: For a bit, `sda_smp_o` pulses exactly once, in high-phase count floor((high byte + 2)/2), and only while SCL is released.
- R6: If another device keeps SCL low for N cycles after release, the whole high phase shifts by N cycles. If SCL is pulled low for N cycles during the high phase, the count pauses and the bit end shifts by N cycles.
- R7: A start from idle waits one full high phase and pulses `sda_sta_o` in its last cycle. It then holds SCL high for one more full high phase, drives SCL low and pulses `done_o`.
- R8: A start accepted while SCL is held low (a repeated start) first runs a low phase with its `sda_upd_o` pulse, then continues as in R7.
- R9: A stop runs a low phase and then a high phase, and pulses `sda_sto_o` in the last cycle of that high phase. After a further high phase it ends with SCL released, `ready_o`=1 and `done_o` pulsed.
- R10: An idle request while SCL is held low releases SCL in the next cycle, with no `done_o` pulse.
- R11: Requests are taken only when `ready_o`=1, with priority start > stop > bit > idle. A bit or stop request while idle is ignored, and so is any request during an operation.
- R12: The divider word is captured when a request is accepted, so changing `div_i` during an operation does not alter its timing.
- R13: `done_o` is a one-cycle pulse. Every transition of `scl_low_o` from 0 to 1 coincides with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | 16 | Divider word: [15:8] high phase, [7:0] low phase |
| scl_i | input | 1 | SCL line as seen on the bus (asynchronous) |
| req_start_i | input | 1 | Start / repeated-start request |
| req_stop_i | input | 1 | Stop request |
| req_bit_i | input | 1 | One data bit clock request |
| req_idle_i | input | 1 | Release SCL and return to idle |
| scl_low_o | output | 1 | 1 = drive SCL low, 0 = release |
| ready_o | output | 1 | A request can be accepted this cycle |
| done_o | output | 1 | Operation finished (one-cycle pulse) |
| sda_upd_o | output | 1 | SDA may change now (mid low phase) |
| sda_smp_o | output | 1 | Sample SDA now (mid high phase) |
| sda_sta_o | output | 1 | Pull SDA low now (start edge) |
| sda_sto_o | output | 1 | Release SDA now (stop edge) |

## Verification
The assertions check on every cycle that the strobes line up with the phase of SCL and that they never overlap. They also check that SCL is newly driven low only together with `done_o`, that `done_o` never lasts two cycles, and that an idle request releases SCL at once. The exact cycle positions are shown only by the directed scenarios: the phase lengths for several divider words (zero, small, and the two bus speeds), the midpoint strobes, and the start and stop edges. The same holds for the shift caused by stretching before and during the high phase, request priority, ignored requests, and immunity to divider changes.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_LOW,
        ST_RISE,
        ST_HIGH,
        ST_HIGH2
    } scl_st_e;

    typedef enum logic [1:0] {
        OP_BIT,
        OP_START,
        OP_STOP
    } scl_op_e;

endpackage

// File: rtl/i2c_scl_sync.sv
module i2c_scl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sync_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) sync_q[g] <= 1'b1;
                else         sync_q[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) sync_q[g] <= 1'b1;
                else         sync_q[g] <= sync_q[g-1];
            end
        end
    end

    assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/i2c_scl_phase_cnt.sv
module i2c_scl_phase_cnt #(
    parameter int CNT_W = 9
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             at_mid_o,
    output logic             at_last_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign at_mid_o  = (cnt_q == (len_i >> 1));
    assign at_last_o = (cnt_q == (len_i - CNT_W'(1)));

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)          cnt_d = '0;
        else if (en_i)      cnt_d = at_last_o ? '0 : cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen
    import i2c_scl_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] div_i,
    input  logic             scl_i,
    input  logic             req_start_i,
    input  logic             req_stop_i,
    input  logic             req_bit_i,
    input  logic             req_idle_i,
    output logic             scl_low_o,
    output logic             ready_o,
    output logic             done_o,
    output logic             sda_upd_o,
    output logic             sda_smp_o,
    output logic             sda_sta_o,
    output logic             sda_sto_o
);
    localparam int HALF_W = DIV_W / 2;
    localparam int CNT_W  = HALF_W + 1;

    typedef struct packed {
        scl_st_e          st;
        scl_op_e          op;
        logic [DIV_W-1:0] div;
        logic             done;
    } gen_regs_t;

    gen_regs_t r_d, r_q;

    logic             scl_hi;
    logic             at_mid, at_last;
    logic             cnt_clr, cnt_en;
    logic [CNT_W-1:0] lo_len, hi_len, len_sel;
    logic             in_low, in_high;

    i2c_scl_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (scl_i),
        .q_o    (scl_hi)
    );

    // Phase lengths: programmed byte plus a fixed offset of two cycles
    assign lo_len  = {1'b0, r_q.div[HALF_W-1:0]}     + CNT_W'(2);
    assign hi_len  = {1'b0, r_q.div[DIV_W-1:HALF_W]} + CNT_W'(2);

    assign in_low  = (r_q.st == ST_LOW);
    assign in_high = (r_q.st == ST_HIGH) || (r_q.st == ST_HIGH2);
    assign len_sel = in_low ? lo_len : hi_len;
    assign cnt_clr = !(in_low || in_high);
    // High-phase count only advances while the line actually reads high
    assign cnt_en  = in_low || (in_high && scl_hi);

    i2c_scl_phase_cnt #(.CNT_W(CNT_W)) cnt_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (cnt_clr),
        .en_i      (cnt_en),
        .len_i     (len_sel),
        .at_mid_o  (at_mid),
        .at_last_o (at_last)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_start_i) begin
                    r_d.op  = OP_START;
                    r_d.div = div_i;
                    r_d.st  = ST_RISE;
                end
            end
            ST_HOLD: begin
                if (req_start_i || req_stop_i || req_bit_i) begin
                    r_d.div = div_i;
                    r_d.st  = ST_LOW;
                    if (req_start_i)     r_d.op = OP_START;
                    else if (req_stop_i) r_d.op = OP_STOP;
                    else                 r_d.op = OP_BIT;
                end else if (req_idle_i) begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_LOW: begin
                if (at_last) r_d.st = ST_RISE;
            end
            ST_RISE: begin
                if (scl_hi) r_d.st = ST_HIGH;
            end
            ST_HIGH: begin
                if (scl_hi && at_last) begin
                    if (r_q.op == OP_BIT) begin
                        r_d.st   = ST_HOLD;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st = ST_HIGH2;
                    end
                end
            end
            ST_HIGH2: begin
                if (scl_hi && at_last) begin
                    r_d.st   = (r_q.op == OP_STOP) ? ST_IDLE : ST_HOLD;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.st   <= ST_IDLE;
            r_q.op   <= OP_BIT;
            r_q.div  <= '0;
            r_q.done <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign scl_low_o = (r_q.st == ST_HOLD) || in_low;
    assign ready_o   = (r_q.st == ST_HOLD) || (r_q.st == ST_IDLE);
    assign done_o    = r_q.done;
    assign sda_upd_o = in_low && at_mid;
    assign sda_smp_o = (r_q.st == ST_HIGH) && (r_q.op == OP_BIT) && scl_hi && at_mid;
    assign sda_sta_o = (r_q.st == ST_HIGH) && (r_q.op == OP_START) && scl_hi && at_last;
    assign sda_sto_o = (r_q.st == ST_HIGH) && (r_q.op == OP_STOP) && scl_hi && at_last;
endmodule

// File: rtl/i2c_scl_gen_chk.sv
module i2c_scl_gen_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic req_start_i,
    input logic req_stop_i,
    input logic req_bit_i,
    input logic req_idle_i,
    input logic scl_low_o,
    input logic ready_o,
    input logic done_o,
    input logic sda_upd_o,
    input logic sda_smp_o,
    input logic sda_sta_o,
    input logic sda_sto_o
);
    // R4
    upd_in_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sda_upd_o |-> scl_low_o);

    // R5
    smp_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sda_smp_o |-> !scl_low_o);

    // R7
    sta_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sda_sta_o |-> !scl_low_o);

    // R9
    sto_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sda_sto_o |-> !scl_low_o);

    // R4
    strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({sda_upd_o, sda_smp_o, sda_sta_o, sda_sto_o}));

    // R13
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R13
    low_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(scl_low_o) |-> done_o);

    // R9
    done_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ready_o);

    // R10
    idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_o && scl_low_o && req_idle_i && !req_start_i && !req_stop_i && !req_bit_i)
        |=> !scl_low_o);
endmodule

bind i2c_scl_gen i2c_scl_gen_chk chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_start_i (req_start_i),
    .req_stop_i  (req_stop_i),
    .req_bit_i   (req_bit_i),
    .req_idle_i  (req_idle_i),
    .scl_low_o   (scl_low_o),
    .ready_o     (ready_o),
    .done_o      (done_o),
    .sda_upd_o   (sda_upd_o),
    .sda_smp_o   (sda_smp_o),
    .sda_sta_o   (sda_sta_o),
    .sda_sto_o   (sda_sto_o)
);

// File: tb/i2c_scl_gen_tb_top.sv
`timescale 1ns/1ps
module i2c_scl_gen_tb_top;
    localparam int SYNC_LAT = 3;  // 2 synchroniser stages + one state cycle

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] div_i = '0;
    logic        req_start = 1'b0, req_stop = 1'b0, req_bit = 1'b0, req_idle = 1'b0;
    logic        scl_low_o, ready_o, done_o, sda_upd_o, sda_smp_o, sda_sta_o, sda_sto_o;
    logic        hold_low = 1'b0, pull_low = 1'b0;
    logic        scl_line;

    int errors = 0, checks = 0;
    int k_upd, n_upd, k_smp, n_smp, k_sta, n_sta, k_sto, n_sto, k_rel, k_low, k_done;

    always #2.5 clk = ~clk;

    assign scl_line = !scl_low_o && !hold_low && !pull_low;

    i2c_scl_gen dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .div_i       (div_i),
        .scl_i       (scl_line),
        .req_start_i (req_start),
        .req_stop_i  (req_stop),
        .req_bit_i   (req_bit),
        .req_idle_i  (req_idle),
        .scl_low_o   (scl_low_o),
        .ready_o     (ready_o),
        .done_o      (done_o),
        .sda_upd_o   (sda_upd_o),
        .sda_smp_o   (sda_smp_o),
        .sda_sta_o   (sda_sta_o),
        .sda_sto_o   (sda_sto_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a negedge; request is seen by the next posedge
    task automatic issue(input logic s, input logic p, input logic b, input logic i,
                         input logic [15:0] div);
        div_i = div;
        req_start = s; req_stop = p; req_bit = b; req_idle = i;
        @(posedge clk);
        #1;
        req_start = 0; req_stop = 0; req_bit = 0; req_idle = 0;
    endtask

    // Sample k=0 is the first negedge after the accepting edge
    task automatic observe(input int limit, input int stretch, input int pull_at,
                           input int pull_len, input int poke_at);
        int left;
        k_upd = -1; k_smp = -1; k_sta = -1; k_sto = -1; k_rel = -1; k_low = -1; k_done = -1;
        n_upd = 0; n_smp = 0; n_sta = 0; n_sto = 0;
        left = stretch;
        hold_low = (stretch > 0);
        for (int k = 0; k < limit; k++) begin
            @(negedge clk);
            if (sda_upd_o) begin n_upd++; if (k_upd < 0) k_upd = k; end
            if (sda_smp_o) begin n_smp++; if (k_smp < 0) k_smp = k; end
            if (sda_sta_o) begin n_sta++; if (k_sta < 0) k_sta = k; end
            if (sda_sto_o) begin n_sto++; if (k_sto < 0) k_sto = k; end
            if (!scl_low_o && k_rel < 0) k_rel = k;
            if (scl_low_o && k_rel >= 0 && k_low < 0) k_low = k;
            if (done_o && k_done < 0) k_done = k;
            hold_low = (left > 0);
            if (!scl_low_o && left > 0) left--;
            if (pull_len > 0 && k == pull_at) pull_low = 1'b1;
            if (pull_len > 0 && k == pull_at + pull_len) pull_low = 1'b0;
            if (k == poke_at) begin req_start = 1'b1; req_stop = 1'b1; end
            if (k == poke_at + 1) begin req_start = 1'b0; req_stop = 1'b0; end
            if (k_done >= 0) break;
        end
        hold_low = 1'b0;
        pull_low = 1'b0;
        req_start = 1'b0; req_stop = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 scl_low after reset", scl_low_o, 0);
        chk("R1 ready after reset", ready_o, 1);
        chk("R1 done after reset", done_o, 0);
        chk("R1 strobes after reset", {sda_upd_o, sda_smp_o, sda_sta_o, sda_sto_o}, 0);
    endtask

    task automatic t_ignored_in_idle();
        issue(0, 1, 1, 0, 16'h0305);
        observe(30, 0, -1, 0, -1);
        chk("R11 stop/bit in idle: no done", k_done, -1);
        chk("R11 stop/bit in idle: SCL stays released", k_low, -1);
        chk("R11 stop/bit in idle: no strobes", n_upd + n_smp + n_sta + n_sto, 0);
        chk("R11 stop/bit in idle: still ready", ready_o, 1);
    endtask

    task automatic t_start(input logic [15:0] div);
        int hi;
        hi = int'(div[15:8]) + 2;
        issue(1, 0, 0, 0, div);
        observe(2000, 0, -1, 0, -1);
        chk("R7 start edge position", k_sta, hi);
        chk("R7 start edge count", n_sta, 1);
        chk("R7 no update strobe from idle", n_upd, 0);
        chk("R7 done position", k_done, 2 * hi + 1);
        chk("R13 SCL low with done", k_low, k_done);
    endtask

    task automatic t_bit(input string tag, input logic [15:0] div, input int s,
                         input int pull_at, input int pull_len, input int poke,
                         input bit chg_div);
        int lo, hi;
        lo = int'(div[7:0]) + 2;
        hi = int'(div[15:8]) + 2;
        issue(0, 0, 1, 0, div);
        if (chg_div) div_i = 16'hFFFF;
        observe(2000, s, pull_at, pull_len, poke);
        chk({tag, " R2 low length"}, k_rel, lo);
        chk({tag, " R4 update position"}, k_upd, lo / 2);
        chk({tag, " R4 update count"}, n_upd, 1);
        chk({tag, " R5 sample position"}, k_smp, lo + SYNC_LAT + s + hi / 2 + pull_len);
        chk({tag, " R5 sample count"}, n_smp, 1);
        chk({tag, " R3 done position"}, k_done, lo + SYNC_LAT + s + hi + pull_len);
        chk({tag, " R13 SCL low with done"}, k_low, k_done);
        chk({tag, " R11 no start/stop edges"}, n_sta + n_sto, 0);
        @(negedge clk);
        chk({tag, " R13 done is one cycle"}, done_o, 0);
        chk({tag, " R2 SCL held low after bit"}, scl_low_o, 1);
    endtask

    task automatic t_rstart(input string tag, input logic [15:0] div,
                            input logic p, input logic b);
        int lo, hi;
        lo = int'(div[7:0]) + 2;
        hi = int'(div[15:8]) + 2;
        issue(1, p, b, 0, div);
        observe(2000, 0, -1, 0, -1);
        chk({tag, " R8 update position"}, k_upd, lo / 2);
        chk({tag, " R8 start edge position"}, k_sta, lo + SYNC_LAT - 1 + hi);
        chk({tag, " R11 no stop edge"}, n_sto, 0);
        chk({tag, " R8 done position"}, k_done, lo + SYNC_LAT + 2 * hi);
        chk({tag, " R8 SCL low with done"}, k_low, k_done);
    endtask

    task automatic t_stop(input string tag, input logic [15:0] div, input logic b);
        int lo, hi;
        lo = int'(div[7:0]) + 2;
        hi = int'(div[15:8]) + 2;
        issue(0, 1, b, 0, div);
        observe(2000, 0, -1, 0, -1);
        chk({tag, " R9 update position"}, k_upd, lo / 2);
        chk({tag, " R9 stop edge position"}, k_sto, lo + SYNC_LAT - 1 + hi);
        chk({tag, " R11 no sample strobe"}, n_smp, 0);
        chk({tag, " R9 done position"}, k_done, lo + SYNC_LAT + 2 * hi);
        chk({tag, " R9 SCL released at end"}, scl_low_o, 0);
        chk({tag, " R9 ready at end"}, ready_o, 1);
    endtask

    task automatic t_idle();
        issue(0, 0, 0, 1, 16'h0305);
        @(negedge clk);
        chk("R10 SCL released after idle", scl_low_o, 0);
        chk("R10 no done for idle", done_o, 0);
        chk("R10 ready after idle", ready_o, 1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ignored_in_idle();
        t_start(16'h0305);
        t_bit("basic", 16'h0305, 0, -1, 0, -1, 1'b0);
        t_bit("R6 stretch before high", 16'h0305, 4, -1, 0, -1, 1'b0);
        // pull low at high-phase count 1 for 5 cycles (lo=9 -> high starts k=12)
        t_bit("R6 pull during high", 16'h0A07, 0, 13, 5, -1, 1'b0);
        t_bit("R12 divider change", 16'h0305, 0, -1, 0, -1, 1'b1);
        t_bit("R11 busy requests", 16'h0305, 0, -1, 0, 4, 1'b0);
        t_rstart("priority start", 16'h0406, 1, 1);
        t_bit("zero divider", 16'h0000, 0, -1, 0, -1, 1'b0);
        t_bit("standard rate", 16'hCFCF, 0, -1, 0, -1, 1'b0);
        t_bit("fast rate", 16'h283C, 0, -1, 0, -1, 1'b0);
        t_stop("priority stop", 16'h0203, 1);
        t_start(16'h0102);
        t_idle();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule